// File: doc/BRIEF.md
# Byte-Lane Configuration Register File

This block is a 64-dword configuration register space behind a minimal target port. A requester presents a dword index, four active-low byte enables, write data, and a read or write strobe for one cycle. The block answers one cycle later with an acknowledge pulse and, for reads, the selected dword. Byte, 16-bit and 32-bit accesses are expressed purely through the byte enables. Byte lane k always maps to bits [8k+7:8k], so the lowest byte address of a dword holds its least significant byte.

Only a handful of dword indices hold real registers. Each has a reset default and a writable-bit mask, and the bits outside that mask are fixed at their default. All other indices behave as empty space: they are acknowledged like any other access, read as zero, and swallow writes. An active-low hard reset returns every register to its default at any time.

Top module: `cfg_regfile`

## Requirements
- R1: While and after hard reset (`rst_n` low), every implemented register reads back its default and `ack` is low.
- R2: Every read or write strobe is answered by `ack` high in exactly the following cycle. `ack` is low in any cycle that does not follow a strobe.
- R3: `req_idx` selects the dword. Byte lane k (k = 0..3) is bits [8k+7:8k] of `req_wdata` and `rdata` and is enabled by `req_be_n[k]`. Lane 0 is the least significant byte, which is byte address 4*index.
- R4: A write changes only the lanes whose enable is low (0). The lanes whose enable is high keep their previous contents.
- R5: In an implemented register, a written bit takes the write data only where its writable mask is 1. Bits where the mask is 0 always read back their default.
- R6: On a read, every lane whose enable is high returns zero.
- R7: Reads of unimplemented indices return zero. Writes to them are acknowledged and change no implemented register.
- R8: `rdata` is zero in every cycle except the one that acknowledges a read.
- R9: Asserting `rst_n` low after registers have been written restores every default.
- R10: The default register map is given as index: default / writable mask. 0x00: 0x1D5C0A07 / 0x00000000. 0x01: 0x00000000 / 0x000003FF. 0x02: 0x0C030011 / 0x00000000. 0x03: 0x00800040 / 0xFF00FF00. 0x10: 0x00000001 / 0xFFFFFFF0. 0x3F: 0x00000000 / 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| req_rd | input | 1 | Read strobe, one cycle per access |
| req_wr | input | 1 | Write strobe, one cycle per access |
| req_idx | input | 6 | Dword index (byte address bits 7:2) |
| req_be_n | input | 4 | Active-low byte enables, bit k controls lane k |
| req_wdata | input | 32 | Write data, little-endian lanes |
| ack | output | 1 | Completion pulse, one cycle after a strobe |
| rdata | output | 32 | Read data, valid with the read acknowledge, zero otherwise |

## Verification
The bench builds the block with its default parameters: 32-bit data, a 6-bit index and the six-register map of R10. That makes the whole 64-dword space small enough to sweep completely. Every index is read after reset, after a series of writes to empty space, and after a reset in the middle of the run. The map mixes a fully read-only dword, a partially writable one, one with fixed and writable lanes interleaved, one with fixed low bits and a fully writable scratch dword. Lane masking, writable masking and the lane-constant storage variant are therefore all exercised on real data.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

   localparam int CFG_DW    = 32;
   localparam int CFG_AW    = 6;
   localparam int CFG_NREGS = 6;

   // Entry 0 is the rightmost element of each table.
   localparam logic [CFG_NREGS-1:0][CFG_AW-1:0] CFG_IDX_TBL = {
      6'h3F, 6'h10, 6'h03, 6'h02, 6'h01, 6'h00
   };

   localparam logic [CFG_NREGS-1:0][CFG_DW-1:0] CFG_DEF_TBL = {
      32'h0000_0000, 32'h0000_0001, 32'h0080_0040,
      32'h0C03_0011, 32'h0000_0000, 32'h1D5C_0A07
   };

   localparam logic [CFG_NREGS-1:0][CFG_DW-1:0] CFG_WMASK_TBL = {
      32'hFFFF_FFFF, 32'hFFFF_FFF0, 32'hFF00_FF00,
      32'h0000_0000, 32'h0000_03FF, 32'h0000_0000
   };

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode #(
   parameter int ADDR_W   = 6,
   parameter int NUM_REGS = 6,
   parameter logic [NUM_REGS-1:0][ADDR_W-1:0] REG_IDX = '0
) (
   input  logic [ADDR_W-1:0]   idx,
   output logic [NUM_REGS-1:0] hit
);

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_match
         assign hit[i] = (idx == REG_IDX[i]);
      end
   endgenerate

endmodule

// File: rtl/cfg_reg_cell.sv
module cfg_reg_cell #(
   parameter int DATA_W = 32,
   parameter int LANES  = DATA_W / 8,
   parameter logic [DATA_W-1:0] DEF   = '0,
   parameter logic [DATA_W-1:0] WMASK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [LANES-1:0]  be_n,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         localparam logic [7:0] LANE_MASK = WMASK[8*k +: 8];
         localparam logic [7:0] LANE_DEF  = DEF[8*k +: 8];

         if (LANE_MASK == 8'h00) begin : g_const
            // Whole lane fixed: no storage.
            assign q[8*k +: 8] = LANE_DEF;
         end else begin : g_store
            logic [7:0] lane_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  lane_q <= LANE_DEF;
               end else if (we && !be_n[k]) begin
                  lane_q <= (wdata[8*k +: 8] & LANE_MASK) |
                            (LANE_DEF & ~LANE_MASK);
               end
            end
            assign q[8*k +: 8] = lane_q;
         end
      end
   endgenerate

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux #(
   parameter int DATA_W   = 32,
   parameter int LANES    = DATA_W / 8,
   parameter int NUM_REGS = 6
) (
   input  logic [NUM_REGS-1:0]             hit,
   input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
   input  logic [LANES-1:0]                be_n,
   output logic [DATA_W-1:0]               dout
);

   logic [DATA_W-1:0] sel;

   always_comb begin
      sel = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (hit[i]) sel = sel | regs[i];
      end
   end

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         assign dout[8*k +: 8] = be_n[k] ? 8'h00 : sel[8*k +: 8];
      end
   endgenerate

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
   parameter int DATA_W   = cfg_space_pkg::CFG_DW,
   parameter int ADDR_W   = cfg_space_pkg::CFG_AW,
   parameter int NUM_REGS = cfg_space_pkg::CFG_NREGS,
   parameter logic [NUM_REGS-1:0][ADDR_W-1:0] REG_IDX   = cfg_space_pkg::CFG_IDX_TBL,
   parameter logic [NUM_REGS-1:0][DATA_W-1:0] REG_DEF   = cfg_space_pkg::CFG_DEF_TBL,
   parameter logic [NUM_REGS-1:0][DATA_W-1:0] REG_WMASK = cfg_space_pkg::CFG_WMASK_TBL
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_rd,
   input  logic                     req_wr,
   input  logic [ADDR_W-1:0]        req_idx,
   input  logic [(DATA_W/8)-1:0]    req_be_n,
   input  logic [DATA_W-1:0]        req_wdata,
   output logic                     ack,
   output logic [DATA_W-1:0]        rdata
);

   localparam int LANES = DATA_W / 8;
   localparam int DEPTH = 1 << ADDR_W;

   // Elaboration-time parameter checks.
   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
         $error("cfg_regfile: DATA_W must be a positive multiple of 8");
      end
      if (NUM_REGS < 1 || NUM_REGS > DEPTH) begin : g_bad_count
         $error("cfg_regfile: NUM_REGS must lie in 1..2**ADDR_W");
      end
      for (genvar a = 0; a < NUM_REGS; a++) begin : g_uniq_a
         for (genvar b = a + 1; b < NUM_REGS; b++) begin : g_uniq_b
            if (REG_IDX[a] == REG_IDX[b]) begin : g_dup
               $error("cfg_regfile: two registers share one index");
            end
         end
      end
   endgenerate

   logic [NUM_REGS-1:0]             hit;
   logic [NUM_REGS-1:0][DATA_W-1:0] reg_q;
   logic [DATA_W-1:0]               rd_comb;
   logic                            ack_q;
   logic [DATA_W-1:0]               rdata_q;

   cfg_addr_decode #(
      .ADDR_W   (ADDR_W),
      .NUM_REGS (NUM_REGS),
      .REG_IDX  (REG_IDX)
   ) u_decode (
      .idx (req_idx),
      .hit (hit)
   );

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         cfg_reg_cell #(
            .DATA_W (DATA_W),
            .LANES  (LANES),
            .DEF    (REG_DEF[i]),
            .WMASK  (REG_WMASK[i])
         ) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (req_wr && hit[i]),
            .be_n  (req_be_n),
            .wdata (req_wdata),
            .q     (reg_q[i])
         );
      end
   endgenerate

   cfg_read_mux #(
      .DATA_W   (DATA_W),
      .LANES    (LANES),
      .NUM_REGS (NUM_REGS)
   ) u_rmux (
      .hit  (hit),
      .regs (reg_q),
      .be_n (req_be_n),
      .dout (rd_comb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         ack_q   <= req_rd || req_wr;
         rdata_q <= req_rd ? rd_comb : '0;
      end
   end

   assign ack   = ack_q;
   assign rdata = rdata_q;

endmodule

// File: rtl/cfg_regfile_chk.sv
module cfg_regfile_chk #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 6,
   parameter int NUM_REGS = 6,
   parameter logic [NUM_REGS-1:0][ADDR_W-1:0] REG_IDX   = '0,
   parameter logic [NUM_REGS-1:0][DATA_W-1:0] REG_DEF   = '0,
   parameter logic [NUM_REGS-1:0][DATA_W-1:0] REG_WMASK = '0
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             req_rd,
   input logic                             req_wr,
   input logic [ADDR_W-1:0]                req_idx,
   input logic [(DATA_W/8)-1:0]            req_be_n,
   input logic                             ack,
   input logic [DATA_W-1:0]                rdata,
   input logic [NUM_REGS-1:0][DATA_W-1:0]  regs
);

   localparam int LANES = DATA_W / 8;

   logic [DATA_W-1:0] off_lanes;
   logic              any_impl;

   always_comb begin
      for (int k = 0; k < LANES; k++) begin
         off_lanes[8*k +: 8] = {8{req_be_n[k]}};
      end
   end

   always_comb begin
      any_impl = 1'b0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (req_idx == REG_IDX[i]) any_impl = 1'b1;
      end
   end

   // R2
   ack_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_rd || req_wr) |=> ack);

   // R2
   no_spurious_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_rd || req_wr) |=> !ack);

   // R8
   rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_rd |=> (rdata == '0));

   // R6
   off_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_rd |=> ((rdata & $past(off_lanes)) == '0));

   // R7
   empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_rd && !any_impl) |=> (rdata == '0));

   // R7
   no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_wr || !any_impl) |=> $stable(regs));

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_fixed
         // R5
         fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((regs[i] & ~REG_WMASK[i]) == (REG_DEF[i] & ~REG_WMASK[i])));
      end
   endgenerate

endmodule

bind cfg_regfile cfg_regfile_chk #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .NUM_REGS  (NUM_REGS),
   .REG_IDX   (REG_IDX),
   .REG_DEF   (REG_DEF),
   .REG_WMASK (REG_WMASK)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_rd   (req_rd),
   .req_wr   (req_wr),
   .req_idx  (req_idx),
   .req_be_n (req_be_n),
   .ack      (ack),
   .rdata    (rdata),
   .regs     (reg_q)
);

// File: tb/cfg_regfile_bench.sv
module cfg_regfile_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_rd = 1'b0;
   logic        req_wr = 1'b0;
   logic [5:0]  req_idx = '0;
   logic [3:0]  req_be_n = 4'hF;
   logic [31:0] req_wdata = '0;
   logic        ack;
   logic [31:0] rdata;

   int n_tests = 0;
   int n_fail  = 0;

   logic [31:0] model [64];

   always #2.5 clk = ~clk;

   cfg_regfile u_cfg_regfile (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_rd    (req_rd),
      .req_wr    (req_wr),
      .req_idx   (req_idx),
      .req_be_n  (req_be_n),
      .req_wdata (req_wdata),
      .ack       (ack),
      .rdata     (rdata)
   );

   // R10 map as stated in the requirements.
   function automatic logic [31:0] map_mask(input int idx);
      case (idx)
         8'h01:   return 32'h0000_03FF;
         8'h03:   return 32'hFF00_FF00;
         8'h10:   return 32'hFFFF_FFF0;
         8'h3F:   return 32'hFFFF_FFFF;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] map_def(input int idx);
      case (idx)
         8'h00:   return 32'h1D5C_0A07;
         8'h02:   return 32'h0C03_0011;
         8'h03:   return 32'h0080_0040;
         8'h10:   return 32'h0000_0001;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] lane_bits(input logic [3:0] be_n);
      logic [31:0] m;
      for (int k = 0; k < 4; k++) m[8*k +: 8] = be_n[k] ? 8'h00 : 8'hFF;
      return m;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 64; i++) model[i] = map_def(i);
   endtask

   task automatic model_write(input int idx, input logic [3:0] be_n,
                              input logic [31:0] d);
      logic [31:0] m;
      m = map_mask(idx) & lane_bits(be_n);
      model[idx] = (model[idx] & ~m) | (d & m);
   endtask

   task automatic chk(input string tag, input logic [31:0] got,
                      input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("[TB] FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   task automatic do_write(input int idx, input logic [3:0] be_n,
                           input logic [31:0] d);
      @(negedge clk);
      req_wr = 1'b1; req_idx = idx[5:0]; req_be_n = be_n; req_wdata = d;
      @(negedge clk);
      req_wr = 1'b0; req_be_n = 4'hF; req_wdata = '0;
      model_write(idx, be_n, d);
   endtask

   task automatic do_read(input int idx, input logic [3:0] be_n,
                          output logic [31:0] d, output logic a);
      @(negedge clk);
      req_rd = 1'b1; req_idx = idx[5:0]; req_be_n = be_n;
      @(negedge clk);
      d = rdata; a = ack;
      req_rd = 1'b0; req_be_n = 4'hF;
   endtask

   task automatic sweep(input string tag);
      logic [31:0] d;
      logic a;
      for (int i = 0; i < 64; i++) begin
         do_read(i, 4'h0, d, a);
         chk(tag, d, model[i]);
      end
   endtask

   task automatic t_reset();
      // R1: ack low during reset, then all defaults
      @(negedge clk);
      chk("R1 ack in reset", {31'b0, ack}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ack after reset", {31'b0, ack}, 32'h0);
      model_reset();
      sweep("R1/R10 default sweep");
   endtask

   task automatic t_handshake();
      logic [31:0] d;
      logic a;
      do_read(8'h02, 4'h0, d, a);
      chk("R2 read ack", {31'b0, a}, 32'h1);
      chk("R3 full dword read", d, 32'h0C03_0011);
      @(negedge clk);
      chk("R2 ack drops", {31'b0, ack}, 32'h0);
      chk("R8 rdata idle", rdata, 32'h0);
      @(negedge clk);
      req_wr = 1'b1; req_idx = 6'h3F; req_be_n = 4'h0; req_wdata = 32'h1234_5678;
      @(negedge clk);
      chk("R2 write ack", {31'b0, ack}, 32'h1);
      chk("R8 rdata on write ack", rdata, 32'h0);
      req_wr = 1'b0; req_be_n = 4'hF;
      model_write(8'h3F, 4'h0, 32'h1234_5678);
      @(negedge clk);
      chk("R2 ack drops after write", {31'b0, ack}, 32'h0);
   endtask

   task automatic t_lanes();
      logic [31:0] d;
      logic a;
      // R3/R4: single-byte writes into the scratch dword, lane by lane
      do_write(8'h3F, 4'b1110, 32'h0000_00AA);
      do_read(8'h3F, 4'h0, d, a);
      chk("R3 lane0 is low byte", d, 32'h1234_56AA);
      do_write(8'h3F, 4'b0111, 32'hC3FF_FFFF);
      do_read(8'h3F, 4'h0, d, a);
      chk("R4 lane3 only", d, 32'hC334_56AA);
      do_write(8'h3F, 4'b1001, 32'hFFBE_EFFF);
      do_read(8'h3F, 4'h0, d, a);
      chk("R4 middle word", d, 32'hC3BE_EFAA);
      // R6: partial reads zero disabled lanes
      do_read(8'h3F, 4'b1010, d, a);
      chk("R6 lanes 0 and 2 only", d, 32'h00BE_00AA);
      do_read(8'h02, 4'b0111, d, a);
      chk("R6 lane 3 only", d, 32'h0C00_0000);
      do_read(8'h3F, 4'hF, d, a);
      chk("R6 no lanes", d, 32'h0);
   endtask

   task automatic t_masks();
      logic [31:0] d;
      logic a;
      do_write(8'h00, 4'h0, 32'hFFFF_FFFF);
      do_read(8'h00, 4'h0, d, a);
      chk("R5 read-only dword", d, 32'h1D5C_0A07);
      do_write(8'h01, 4'h0, 32'hFFFF_FFFF);
      do_read(8'h01, 4'h0, d, a);
      chk("R5 partial mask", d, 32'h0000_03FF);
      do_write(8'h03, 4'h0, 32'hFFFF_FFFF);
      do_read(8'h03, 4'h0, d, a);
      chk("R5 interleaved lanes", d, 32'hFF80_FF40);
      do_write(8'h10, 4'h0, 32'h0000_0000);
      do_read(8'h10, 4'h0, d, a);
      chk("R5 fixed low bits", d, 32'h0000_0001);
      do_write(8'h10, 4'b0011, 32'hABCD_FFFF);
      do_read(8'h10, 4'h0, d, a);
      chk("R4 upper word write", d, 32'hABCD_0001);
   endtask

   task automatic t_empty();
      logic [31:0] d;
      logic a;
      do_write(8'h05, 4'h0, 32'hFFFF_FFFF);
      do_write(8'h20, 4'h0, 32'hA5A5_A5A5);
      do_write(8'h11, 4'h0, 32'h5A5A_5A5A);
      do_read(8'h20, 4'h0, d, a);
      chk("R7 empty read ack", {31'b0, a}, 32'h1);
      chk("R7 empty read zero", d, 32'h0);
      sweep("R7 sweep after empty writes");
   endtask

   task automatic t_hard_reset();
      do_write(8'h3F, 4'h0, 32'hFEED_F00D);
      do_write(8'h01, 4'h0, 32'h0000_0155);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R9 ack low in reset", {31'b0, ack}, 32'h0);
      rst_n = 1'b1;
      model_reset();
      sweep("R9 defaults restored");
   endtask

   initial begin
      #(200000 * 5);
      n_tests++;
      n_fail++;
      $display("[TB] FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_handshake();
      t_lanes();
      t_masks();
      t_empty();
      t_hard_reset();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule